// File: doc/BRIEF.md
# Robust Add-With-Carry Unit

This block adds two 32-bit words and a carry-in, and checks its own sum for faults with a nonlinear quadratic residue code. The modulus is the prime p = 2^32 - 5. It forms the square of the true total, (a + b + cin)^2 mod p, from residues of the operands alone. It forms a second residue from the produced carry-out and sum word, using the identity 2^32 = 5 (mod p). If the two residues differ, it raises a fault flag. An attacker who flips bits in the stored result cannot predict which patterns cancel, because the check is quadratic in the data and not a linear parity.

An operation is offered with a valid/ready handshake. The sum and carry appear one cycle after the accepting edge, with a one-cycle result strobe. The check verdict follows two cycles after that, with its own strobe. While an operation is in flight the unit reports not-ready, so the next operands are taken only once the check has finished. A fault-mask input is XORed into the 33-bit result as it is registered. This lets a test or a fault campaign corrupt the stored value and watch the detector respond.

Top module: `resadd_top`

## Requirements
- R1: While reset is held and after it is released, in_ready_o is 1, and res_valid_o, chk_valid_o, fault_o, sum_o and cout_o are all 0.
- R2: An operation is accepted on a rising edge where in_valid_i and in_ready_o are both 1. in_ready_o is then 0 for the next three cycles and returns to 1 in the cycle where chk_valid_o is 1.
- R3: res_valid_o is 1 for exactly one cycle, the second cycle after the accepting edge. In that cycle {cout_o, sum_o} equals a + b + cin as a 33-bit value when the fault mask is zero.
- R4: chk_valid_o is 1 for exactly one cycle, two cycles after the cycle in which res_valid_o is 1.
- R5: With a zero fault mask, fault_o is 0 when chk_valid_o is 1, for all operands, including a = b = 0xFFFFFFFF with cin = 1 and totals at or above p.
- R6: The 33-bit fault mask captured with the operands is XORed into the result: mask bit 32 flips cout_o and mask bits 31:0 flip sum_o bit for bit.
- R7: When chk_valid_o is 1, fault_o is 1 exactly when (corrupted 33-bit result)^2 mod p differs from (a + b + cin)^2 mod p, with p = 0xFFFFFFFB.
- R8: sum_o and cout_o hold their value except in a cycle where res_valid_o is 1. fault_o holds its value except in a cycle where chk_valid_o is 1.
- R9: in_valid_i and the operand inputs are ignored while in_ready_o is 0: no extra result strobe follows, and the pending result is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands offered this cycle |
| in_ready_o | output | 1 | Unit idle and able to accept operands |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| cin_i | input | 1 | Carry-in |
| fmask_i | input | 33 | Fault mask XORed into {carry, sum}; bit 32 is the carry |
| sum_o | output | 32 | Registered sum word |
| cout_o | output | 1 | Registered carry-out |
| res_valid_o | output | 1 | One-cycle strobe: sum and carry updated |
| chk_valid_o | output | 1 | One-cycle strobe: fault verdict updated |
| fault_o | output | 1 | Residue mismatch verdict of the last operation |

## Verification
The bench drives all-ones operands with a carry-in, where the carry term and its constants 25 and 10 must be right. A wrong constant would raise a false flag there. It drives totals just at and above p, where a reduction that skips the final subtraction leaves a non-canonical residue, so the comparison fails on clean data. It flips every single result bit, including the carry alone, and applies wide multi-bit masks. A detector that ignored the carry or used the sum word alone would miss these faults. It also raises in_valid_i with junk operands mid-flight, which a handshake that ignores busy would turn into an unexpected extra result.

// File: rtl/resadd_pkg.sv
package resadd_pkg;

  // Data width and the distance of the prime modulus below 2^DW.
  // The folding reduction assumes PDELTA is small (below 8).
  parameter int unsigned DW     = 32;
  parameter int unsigned PDELTA = 5;

  localparam int unsigned RW = DW + 1;  // carry plus sum
  localparam int unsigned TW = DW + 4;  // first fold width

  typedef logic [DW-1:0]   word_t;
  typedef logic [2*DW-1:0] dword_t;
  typedef logic [RW-1:0]   raw_t;

  localparam word_t PMOD  = {DW{1'b1}} - word_t'(PDELTA - 1);
  // 2^(2*DW) mod p and 2^(DW+1) mod p
  localparam word_t C_HI2 = word_t'(PDELTA * PDELTA);
  localparam word_t C_HI1 = word_t'(2 * PDELTA);

  // Bring a value below 2^DW into [0, p).
  function automatic word_t rz_canon(input word_t x);
    return (x >= PMOD) ? (x - PMOD) : x;
  endfunction

  // Reduce a double-width value modulo p by folding the high part.
  function automatic word_t rz_reduce(input dword_t x);
    logic [TW-1:0] t;
    logic [DW:0]   u;
    word_t         v;
    t = TW'(x[DW-1:0]) + TW'(x[2*DW-1:DW]) * TW'(PDELTA);
    u = (DW+1)'(t[DW-1:0]) + (DW+1)'(t[TW-1:DW]) * (DW+1)'(PDELTA);
    v = u[DW-1:0] + (u[DW] ? word_t'(PDELTA) : '0);
    return rz_canon(v);
  endfunction

  // Modular sum of two canonical residues.
  function automatic word_t rz_addm(input word_t x, input word_t y);
    logic [DW:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= {1'b0, PMOD}) s = s - {1'b0, PMOD};
    return s[DW-1:0];
  endfunction

  function automatic word_t rz_mul(input word_t x, input word_t y);
    return rz_reduce(dword_t'(x) * dword_t'(y));
  endfunction

  function automatic word_t rz_sqr(input word_t x);
    return rz_mul(x, x);
  endfunction

endpackage

// File: rtl/resadd_ctrl.sv
module resadd_ctrl #(
  parameter int unsigned NSTG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept_i,
  output logic [NSTG-1:0] stg_o,
  output logic            ready_o
);

  // Stages before the last one keep the unit busy.
  localparam int unsigned BUSY_N = NSTG - 1;

  logic [NSTG-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[NSTG-2:0], accept_i};
  end

  assign stg_o   = stg_q;
  assign ready_o = ~|stg_q[BUSY_N-1:0];

endmodule

// File: rtl/resadd_insq.sv
module resadd_insq
  import resadd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld1_i,
  input  logic  ld2_i,
  input  word_t a_i,
  input  word_t b_i,
  input  logic  cin_i,
  output word_t in_res_o
);

  word_t  sq_a_w, sq_b_w, cross_w, cross_half_w;
  dword_t cross_raw_w;
  word_t  sq_a_q, sq_b_q, cross_q, in_res_q;

  // 2*(a*b + cin*(a+b)) + cin, all modulo p
  always_comb begin
    sq_a_w       = rz_sqr(a_i);
    sq_b_w       = rz_sqr(b_i);
    cross_raw_w  = dword_t'(a_i) * dword_t'(b_i)
                 + (cin_i ? dword_t'({1'b0, a_i} + {1'b0, b_i}) : '0);
    cross_half_w = rz_reduce(cross_raw_w);
    cross_w      = rz_addm(rz_addm(cross_half_w, cross_half_w), word_t'(cin_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_a_q  <= '0;
      sq_b_q  <= '0;
      cross_q <= '0;
    end else if (ld1_i) begin
      sq_a_q  <= sq_a_w;
      sq_b_q  <= sq_b_w;
      cross_q <= cross_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     in_res_q <= '0;
    else if (ld2_i) in_res_q <= rz_addm(rz_addm(sq_a_q, sq_b_q), cross_q);
  end

  assign in_res_o = in_res_q;

endmodule

// File: rtl/resadd_outsq.sv
module resadd_outsq
  import resadd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld1_i,
  input  logic  ld2_i,
  input  word_t a_i,
  input  word_t b_i,
  input  logic  cin_i,
  input  raw_t  mask_i,
  output word_t sum_o,
  output logic  cout_o,
  output word_t out_res_o
);

  raw_t  raw_w;
  raw_t  res_q;
  word_t lo_w, hi_term_w, out_res_w, out_res_q;
  logic  hi_w;

  assign raw_w = {1'b0, a_i} + {1'b0, b_i} + raw_t'(cin_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     res_q <= '0;
    else if (ld1_i) res_q <= raw_w ^ mask_i;
  end

  // (hi*2^DW + lo)^2 mod p, with hi in {0,1}
  always_comb begin
    lo_w      = res_q[DW-1:0];
    hi_w      = res_q[DW];
    hi_term_w = rz_addm(C_HI2, rz_mul(rz_canon(lo_w), C_HI1));
    out_res_w = rz_addm(rz_sqr(lo_w), hi_w ? hi_term_w : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_res_q <= '0;
    else if (ld2_i) out_res_q <= out_res_w;
  end

  assign sum_o     = res_q[DW-1:0];
  assign cout_o    = res_q[DW];
  assign out_res_o = out_res_q;

endmodule

// File: rtl/resadd_top.sv
module resadd_top
  import resadd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [31:0]   opa_i,
  input  logic [31:0]   opb_i,
  input  logic          cin_i,
  input  logic [32:0]   fmask_i,
  output logic [31:0]   sum_o,
  output logic          cout_o,
  output logic          res_valid_o,
  output logic          chk_valid_o,
  output logic          fault_o
);

  localparam int unsigned NSTG   = 4;
  localparam int unsigned ST_LD1 = 0;
  localparam int unsigned ST_RES = 1;
  localparam int unsigned ST_CMP = 2;
  localparam int unsigned ST_CHK = NSTG - 1;

  logic            accept_w;
  logic [NSTG-1:0] stg_w;
  word_t           a_q, b_q;
  logic            cin_q;
  raw_t            mask_q;
  word_t           in_res_w, out_res_w;
  logic            res_mismatch_w;
  logic            fault_q;

  assign accept_w = in_valid_i & in_ready_o;

  resadd_ctrl #(.NSTG(NSTG)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept_w),
    .stg_o    (stg_w),
    .ready_o  (in_ready_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      cin_q  <= 1'b0;
      mask_q <= '0;
    end else if (accept_w) begin
      a_q    <= opa_i;
      b_q    <= opb_i;
      cin_q  <= cin_i;
      mask_q <= fmask_i;
    end
  end

  resadd_insq u_insq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld1_i    (stg_w[ST_LD1]),
    .ld2_i    (stg_w[ST_RES]),
    .a_i      (a_q),
    .b_i      (b_q),
    .cin_i    (cin_q),
    .in_res_o (in_res_w)
  );

  resadd_outsq u_outsq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld1_i     (stg_w[ST_LD1]),
    .ld2_i     (stg_w[ST_RES]),
    .a_i       (a_q),
    .b_i       (b_q),
    .cin_i     (cin_q),
    .mask_i    (mask_q),
    .sum_o     (sum_o),
    .cout_o    (cout_o),
    .out_res_o (out_res_w)
  );

  assign res_mismatch_w = (in_res_w != out_res_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              fault_q <= 1'b0;
    else if (stg_w[ST_CMP])  fault_q <= res_mismatch_w;
  end

  assign fault_o     = fault_q;
  assign res_valid_o = stg_w[ST_RES];
  assign chk_valid_o = stg_w[ST_CHK];

endmodule

// File: rtl/resadd_chk.sv
module resadd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc,
  input logic        rdy,
  input logic        rv,
  input logic        cv,
  input logic        flt,
  input logic [32:0] mask_cap
);

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !rdy);

  p_ready_on_check_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cv |-> rdy);

  p_result_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> ##2 rv);

  p_result_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rv |=> !rv);

  p_check_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rv |-> ##2 cv);

  p_clean_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cv && (mask_cap == '0)) |-> !flt);

  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cv |-> $stable(flt));

endmodule

bind resadd_top resadd_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc      (accept_w),
  .rdy      (in_ready_o),
  .rv       (res_valid_o),
  .cv       (chk_valid_o),
  .flt      (fault_o),
  .mask_cap (mask_q)
);

// File: tb/resadd_top_test.sv
module resadd_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        cin_i = 1'b0;
  logic [32:0] fmask_i = '0;
  logic [31:0] sum_o;
  logic        cout_o;
  logic        res_valid_o;
  logic        chk_valid_o;
  logic        fault_o;

  int n_cmp = 0;
  int n_bad = 0;

  localparam logic [71:0] PBIG = 72'h0_0000_0000_FFFF_FFFB;

  // scoreboard queues: {mask_zero, corrupted result} and {mask_zero, fault}
  logic [33:0] exp_res_q[$];
  logic [1:0]  exp_flt_q[$];

  always #10 clk = ~clk;  // 50 MHz

  resadd_top uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .cin_i       (cin_i),
    .fmask_i     (fmask_i),
    .sum_o       (sum_o),
    .cout_o      (cout_o),
    .res_valid_o (res_valid_o),
    .chk_valid_o (chk_valid_o),
    .fault_o     (fault_o)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [71:0] sq_mod(input logic [32:0] v);
    logic [71:0] w;
    w = 72'(v);
    return (w * w) % PBIG;
  endfunction

  task automatic send(input logic [31:0] a, input logic [31:0] b,
                      input logic c, input logic [32:0] m, input bit junk);
    logic [32:0] tru, cor;
    bit f, mz;
    tru = {1'b0, a} + {1'b0, b} + 33'(c);
    cor = tru ^ m;
    f   = (sq_mod(cor) != sq_mod(tru));
    mz  = (m == '0);
    @(negedge clk);
    while (!in_ready_o) @(negedge clk);
    opa_i = a; opb_i = b; cin_i = c; fmask_i = m; in_valid_i = 1'b1;
    exp_res_q.push_back({mz, cor});
    exp_flt_q.push_back({mz, f});
    @(negedge clk);
    in_valid_i = 1'b0;
    chk(in_ready_o === 1'b0, "R2 busy cycle 1", 64'(in_ready_o), 64'd0);
    if (junk) begin
      // R9: offer different operands while busy
      opa_i = ~a; opb_i = 32'h1234_5678; cin_i = ~c; fmask_i = 33'h1_0000_0003;
      in_valid_i = 1'b1;
    end
    @(negedge clk);
    in_valid_i = 1'b0;
    chk(in_ready_o === 1'b0, "R2 busy cycle 2", 64'(in_ready_o), 64'd0);
    @(negedge clk);
    chk(in_ready_o === 1'b0, "R2 busy cycle 3", 64'(in_ready_o), 64'd0);
    @(negedge clk);
    chk(in_ready_o === 1'b1, "R2 ready with check strobe", 64'(in_ready_o), 64'd1);
  endtask

  // monitor
  logic [32:0] last_res = '0;
  logic        last_flt = 1'b0;
  int          since_res = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid_o) begin
        since_res = 0;
        if (exp_res_q.size() == 0) begin
          chk(1'b0, "R9 unexpected result strobe", 64'({cout_o, sum_o}), 64'd0);
        end else begin
          logic [33:0] e;
          e = exp_res_q.pop_front();
          chk({cout_o, sum_o} === e[32:0],
              e[33] ? "R3 carry and sum" : "R6 masked carry and sum",
              64'({cout_o, sum_o}), 64'(e[32:0]));
        end
        last_res = {cout_o, sum_o};
      end else begin
        since_res++;
        chk({cout_o, sum_o} === last_res, "R8 result held",
            64'({cout_o, sum_o}), 64'(last_res));
      end
      if (chk_valid_o) begin
        chk(since_res == 2, "R4 check two cycles after result", 64'(since_res), 64'd2);
        if (exp_flt_q.size() == 0) begin
          chk(1'b0, "R4 unexpected check strobe", 64'(fault_o), 64'd0);
        end else begin
          logic [1:0] g;
          g = exp_flt_q.pop_front();
          chk(fault_o === g[0], g[1] ? "R5 clean operation flag" : "R7 fault flag",
              64'(fault_o), 64'(g[0]));
        end
        last_flt = fault_o;
      end else begin
        chk(fault_o === last_flt, "R8 flag held", 64'(fault_o), 64'(last_flt));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R2 watchdog expired act=hung exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while held
    chk(in_ready_o === 1'b1, "R1 ready in reset", 64'(in_ready_o), 64'd1);
    chk({res_valid_o, chk_valid_o, fault_o} === 3'b000, "R1 strobes and flag in reset",
        64'({res_valid_o, chk_valid_o, fault_o}), 64'd0);
    chk({cout_o, sum_o} === 33'd0, "R1 result in reset", 64'({cout_o, sum_o}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready_o === 1'b1, "R1 ready after reset", 64'(in_ready_o), 64'd1);
    chk({res_valid_o, chk_valid_o, fault_o} === 3'b000, "R1 idle after reset",
        64'({res_valid_o, chk_valid_o, fault_o}), 64'd0);

    // R3/R5 corners
    send(32'h0, 32'h0, 1'b0, 33'h0, 1'b0);
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 33'h0, 1'b0);
    send(32'hFFFF_FFFF, 32'h1, 1'b0, 33'h0, 1'b0);
    send(32'hFFFF_FFFB, 32'h0, 1'b0, 33'h0, 1'b0);
    send(32'hFFFF_FFFA, 32'h0, 1'b1, 33'h0, 1'b0);
    send(32'hFFFF_FFFC, 32'h3, 1'b1, 33'h0, 1'b0);
    send(32'h8000_0000, 32'h8000_0000, 1'b0, 33'h0, 1'b0);
    send(32'hFFFF_FFFB, 32'hFFFF_FFFB, 1'b1, 33'h0, 1'b0);

    // R5 random clean operands
    for (int i = 0; i < 60; i++)
      send($urandom, $urandom, 1'($urandom), 33'h0, 1'b0);

    // R9 junk offered while busy
    send(32'h0000_1111, 32'h0000_2222, 1'b0, 33'h0, 1'b1);
    send(32'hDEAD_BEEF, 32'h0BAD_F00D, 1'b1, 33'h0, 1'b1);

    // R6/R7 single-bit faults on every result bit, including the carry
    for (int i = 0; i < 33; i++)
      send($urandom, $urandom, 1'($urandom), 33'h1 << i, 1'b0);
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 33'h1_0000_0000, 1'b0);
    send(32'h0, 32'h0, 1'b0, 33'h1_0000_0000, 1'b0);

    // R6/R7 multi-bit faults
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 33'h1_FFFF_FFFF, 1'b0);
    send(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 33'h0_FFFF_FFFF, 1'b0);
    send(32'h0000_0005, 32'h0, 1'b0, 33'h1_0000_0001, 1'b0);
    send(32'hFFFF_FFFB, 32'h0, 1'b0, 33'h0_0000_0005, 1'b0);
    for (int i = 0; i < 20; i++)
      send($urandom, $urandom, 1'($urandom), {1'($urandom), 32'($urandom)}, 1'b0);

    repeat (6) @(negedge clk);
    chk(exp_res_q.size() == 0, "R3 all results seen", 64'(exp_res_q.size()), 64'd0);
    chk(exp_flt_q.size() == 0, "R4 all checks seen", 64'(exp_flt_q.size()), 64'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule